// File: doc/BRIEF.md
# Accumulator ALU with Carry Flag

This block is the arithmetic heart of a small accumulator machine. A controller presents the current accumulator, an operand and a three-bit function code. The block returns the value the accumulator should take next. It also returns the carry or borrow the operation would leave behind. The block keeps a one-bit carry register of its own. That register loads only when the controller raises a commit strobe, so a multi-byte addition or subtraction can be built from one plain step followed by carry-consuming steps.

A separate shift mode, selected by its own input, replaces the function path. It moves the accumulator by one bit in one of four ways, and the bit that leaves the word goes into the carry. A zero output tells the branch logic whether the accumulator the machine currently holds is all zeros. The data width is a parameter. An option chooses how subtraction is built in hardware; both choices give the same values at the ports.

Top module: `acc_alu_core`

## Requirements
- R1: With shift mode off, function 000 gives acc+opnd modulo 2^WIDTH, and the flag it offers is the carry-out. Function 001 gives acc-opnd, and the flag it offers is 1 exactly when opnd > acc as unsigned values.
- R2: Function 010 gives acc+opnd+carry, with the carry-out offered as the new flag. Function 011 gives acc-opnd-carry, with the flag offered as 1 exactly when opnd+carry > acc. Here carry is the stored flag.
- R3: Functions 100, 101 and 110 give the bitwise AND, OR and XOR of acc and opnd.
- R4: Function 111 passes opnd to the result unchanged.
- R5: For functions 100 to 111, the offered flag equals the stored flag, so committing such an operation leaves the carry unchanged.
- R6: The stored carry clears on reset. At a rising clock edge it loads the offered flag when commit is high, and holds when commit is low.
- R7: With shift mode on, code 00 shifts left and inserts 0, and code 01 shifts right and inserts 0. The bit shifted out is offered as the new flag, and the function code is ignored.
- R8: With shift mode on, code 10 rotates left through the carry: the stored flag enters bit 0 and the old top bit becomes the offered flag. Code 11 rotates right through the carry: the stored flag enters the top bit and the old bit 0 becomes the offered flag.
- R9: The zero output is high exactly when the accumulator input equals 0.
- R10: Chaining one 000 step with 010 steps, byte by byte from the low byte, forms a multi-byte sum whose final stored carry is the carry-out of the full width. Chaining one 001 step with 011 steps in the same way does the same for a difference and its borrow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_i | input | WIDTH | Current accumulator value |
| opnd_i | input | WIDTH | Operand |
| func_i | input | 3 | Function code (R1 to R4) |
| shift_en_i | input | 1 | Selects the shift path instead of the function path |
| shift_code_i | input | 2 | Shift or rotate code (R7, R8) |
| commit_i | input | 1 | Loads the offered flag into the carry register |
| result_o | output | WIDTH | Next accumulator value |
| carry_next_o | output | 1 | Flag value that a commit would store |
| carry_o | output | 1 | Stored carry flag |
| zero_o | output | 1 | High when acc_i is zero |

## Verification
The bench builds two copies of the block. The first uses WIDTH=4, which makes a full sweep feasible: every accumulator, every operand, all eight functions and both stored carry values for the function path, and every accumulator with both carries and all four codes for the shift path. The second uses the default WIDTH=8 and runs four-byte add and subtract chains that cross the 0xFF/0x00 boundary in several bytes at once. On this copy the bench also checks commit gating, flag retention under the logical functions and load, and reset.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   // Function codes of the operand path. Bit 2 separates arithmetic from
   // logical functions, bit 1 selects carry use, bit 0 selects subtraction.
   typedef enum logic [2:0] {
      FN_ADD  = 3'b000,
      FN_SUB  = 3'b001,
      FN_ADC  = 3'b010,
      FN_SBB  = 3'b011,
      FN_AND  = 3'b100,
      FN_OR   = 3'b101,
      FN_XOR  = 3'b110,
      FN_LOAD = 3'b111
   } alu_fn_e;

   // Shift path codes; bit 1 selects rotation through the carry,
   // bit 0 selects the right direction.
   typedef enum logic [1:0] {
      SH_LSL = 2'b00,
      SH_LSR = 2'b01,
      SH_RCL = 2'b10,
      SH_RCR = 2'b11
   } shift_code_e;

   // Selector of the logical unit, taken from the low two function bits.
   typedef enum logic [1:0] {
      LG_AND  = 2'b00,
      LG_OR   = 2'b01,
      LG_XOR  = 2'b10,
      LG_PASS = 2'b11
   } logic_sel_e;

endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith #(
   parameter int WIDTH      = 8,
   parameter bit INVERT_SUB = 1'b1
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             sub_i,
   input  logic             use_cin_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o
);

   localparam int EXT = WIDTH + 1;

   logic cin_eff;
   assign cin_eff = use_cin_i & cin_i;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("acc_alu_arith: WIDTH must be at least 2");
      end

      if (INVERT_SUB) begin : g_invert
         // Subtraction as a + ~b + ~borrow; borrow is the missing carry-out.
         logic [WIDTH-1:0] b_eff;
         logic             c_eff;
         logic [EXT-1:0]   total;

         always_comb begin
            b_eff = sub_i ? ~b_i : b_i;
            c_eff = sub_i ? ~cin_eff : cin_eff;
            total = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, c_eff};
         end

         assign sum_o  = total[WIDTH-1:0];
         assign cout_o = sub_i ? ~total[WIDTH] : total[WIDTH];
      end else begin : g_direct
         // Separate adder and subtractor; the extra bit is carry or borrow.
         logic [EXT-1:0] total;

         always_comb begin
            if (sub_i) begin
               total = {1'b0, a_i} - {1'b0, b_i} - {{WIDTH{1'b0}}, cin_eff};
            end else begin
               total = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_eff};
            end
         end

         assign sum_o  = total[WIDTH-1:0];
         assign cout_o = total[WIDTH];
      end
   endgenerate

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
   import acc_alu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic_sel_e       sel_i,
   output logic [WIDTH-1:0] y_o
);

   always_comb begin
      unique case (sel_i)
         LG_AND:  y_o = a_i & b_i;
         LG_OR:   y_o = a_i | b_i;
         LG_XOR:  y_o = a_i ^ b_i;
         default: y_o = b_i;
      endcase
   end

endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift
   import acc_alu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic             cin_i,
   input  shift_code_e      code_i,
   output logic [WIDTH-1:0] y_o,
   output logic             cout_o
);

   localparam int MSB = WIDTH - 1;

   logic fill;
   logic right;

   always_comb begin
      right = code_i[0];
      // Rotations feed the stored carry in; plain shifts feed zero.
      fill  = code_i[1] ? cin_i : 1'b0;
      if (right) begin
         y_o    = {fill, a_i[MSB:1]};
         cout_o = a_i[0];
      end else begin
         y_o    = {a_i[MSB-1:0], fill};
         cout_o = a_i[MSB];
      end
   end

endmodule

// File: rtl/acc_alu_flag.sv
module acc_alu_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic d_i,
   output logic q_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_o <= 1'b0;
      end else if (load_i) begin
         q_o <= d_i;
      end
   end

endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
   import acc_alu_pkg::*;
#(
   parameter int WIDTH      = 8,
   parameter bit INVERT_SUB = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] acc_i,
   input  logic [WIDTH-1:0] opnd_i,
   input  logic [2:0]       func_i,
   input  logic             shift_en_i,
   input  logic [1:0]       shift_code_i,
   input  logic             commit_i,
   output logic [WIDTH-1:0] result_o,
   output logic             carry_next_o,
   output logic             carry_o,
   output logic             zero_o
);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("acc_alu_core: WIDTH must be at least 2");
      end
   endgenerate

   alu_fn_e          fn;
   logic             is_arith;
   logic [WIDTH-1:0] arith_y;
   logic             arith_c;
   logic [WIDTH-1:0] logic_y;
   logic [WIDTH-1:0] shift_y;
   logic             shift_c;
   logic             carry_q;

   assign fn       = alu_fn_e'(func_i);
   assign is_arith = ~fn[2];

   acc_alu_arith #(
      .WIDTH      (WIDTH),
      .INVERT_SUB (INVERT_SUB)
   ) u_arith (
      .a_i       (acc_i),
      .b_i       (opnd_i),
      .sub_i     (fn[0]),
      .use_cin_i (fn[1]),
      .cin_i     (carry_q),
      .sum_o     (arith_y),
      .cout_o    (arith_c)
   );

   acc_alu_logic #(
      .WIDTH (WIDTH)
   ) u_logic (
      .a_i   (acc_i),
      .b_i   (opnd_i),
      .sel_i (logic_sel_e'(fn[1:0])),
      .y_o   (logic_y)
   );

   acc_alu_shift #(
      .WIDTH (WIDTH)
   ) u_shift (
      .a_i    (acc_i),
      .cin_i  (carry_q),
      .code_i (shift_code_e'(shift_code_i)),
      .y_o    (shift_y),
      .cout_o (shift_c)
   );

   always_comb begin
      if (shift_en_i) begin
         result_o     = shift_y;
         carry_next_o = shift_c;
      end else if (is_arith) begin
         result_o     = arith_y;
         carry_next_o = arith_c;
      end else begin
         result_o     = logic_y;
         carry_next_o = carry_q;
      end
   end

   acc_alu_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (commit_i),
      .d_i    (carry_next_o),
      .q_o    (carry_q)
   );

   assign carry_o = carry_q;
   assign zero_o  = (acc_i == '0);

endmodule

// File: rtl/acc_alu_core_chk.sv
module acc_alu_core_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [WIDTH-1:0] acc_i,
   input logic [WIDTH-1:0] opnd_i,
   input logic [2:0]       func_i,
   input logic             shift_en_i,
   input logic [1:0]       shift_code_i,
   input logic             commit_i,
   input logic [WIDTH-1:0] result_o,
   input logic             carry_next_o,
   input logic             carry_o,
   input logic             zero_o
);

   // R1: plain add matches a widened sum.
   p_add_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!shift_en_i && func_i == 3'b000)
         |-> {carry_next_o, result_o} == ({1'b0, acc_i} + {1'b0, opnd_i}));

   // R4: load passes the operand.
   p_load_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!shift_en_i && func_i == 3'b111) |-> result_o == opnd_i);

   // R5: logical functions and load offer the stored flag.
   p_logic_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!shift_en_i && func_i[2]) |-> carry_next_o == carry_o);

   // R6: no commit, no change.
   p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !commit_i |=> $stable(carry_o));

   // R6: a commit stores the offered flag.
   p_commit_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      commit_i |=> carry_o == $past(carry_next_o));

   // R7: left shift inserts zero and offers the old top bit.
   p_lsl_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en_i && shift_code_i == 2'b00)
         |-> (result_o[0] == 1'b0) && (carry_next_o == acc_i[WIDTH-1]));

   // R8: rotate left through carry feeds the stored flag into bit 0.
   p_rcl_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en_i && shift_code_i == 2'b10) |-> result_o[0] == carry_o);

   // R9: loading zero through a zero accumulator agrees with the zero flag.
   p_zero_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!shift_en_i && func_i == 3'b111 && opnd_i == acc_i)
         |-> zero_o == (result_o == '0));

endmodule

bind acc_alu_core acc_alu_core_chk #(
   .WIDTH (WIDTH)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .acc_i        (acc_i),
   .opnd_i       (opnd_i),
   .func_i       (func_i),
   .shift_en_i   (shift_en_i),
   .shift_code_i (shift_code_i),
   .commit_i     (commit_i),
   .result_o     (result_o),
   .carry_next_o (carry_next_o),
   .carry_o      (carry_o),
   .zero_o       (zero_o)
);

// File: tb/test_acc_alu_core.sv
module test_acc_alu_core;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   int   n_checks = 0;
   int   n_errors = 0;
   bit   done = 1'b0;

   always #10 clk = ~clk;

   // Wide instance (default width)
   logic [7:0] a8, b8, r8;
   logic [2:0] f8;
   logic [1:0] sc8;
   logic       se8, cm8, cn8, c8, z8;

   acc_alu_core #(.WIDTH(8)) i_acc_alu_core (
      .clk(clk), .rst_n(rst_n), .acc_i(a8), .opnd_i(b8), .func_i(f8),
      .shift_en_i(se8), .shift_code_i(sc8), .commit_i(cm8),
      .result_o(r8), .carry_next_o(cn8), .carry_o(c8), .zero_o(z8));

   // Narrow instance for full sweeps
   logic [3:0] a4, b4, r4;
   logic [2:0] f4;
   logic [1:0] sc4;
   logic       se4, cm4, cn4, c4, z4;

   acc_alu_core #(.WIDTH(4), .INVERT_SUB(1'b0)) i_acc_alu_core_w4 (
      .clk(clk), .rst_n(rst_n), .acc_i(a4), .opnd_i(b4), .func_i(f4),
      .shift_en_i(se4), .shift_code_i(sc4), .commit_i(cm4),
      .result_o(r4), .carry_next_o(cn4), .carry_o(c4), .zero_o(z4));

   task automatic check(input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Reference for the function path: returns {flag, result}.
   function automatic int ref_fn(int w, int f, int a, int b, int c);
      int m = (1 << w) - 1;
      int s;
      int co;
      case (f)
         0: begin s = a + b;     co = (s >> w) & 1; end
         1: begin s = a - b;     co = (b > a) ? 1 : 0; end
         2: begin s = a + b + c; co = (s >> w) & 1; end
         3: begin s = a - b - c; co = (b + c > a) ? 1 : 0; end
         4: begin s = a & b; co = c; end
         5: begin s = a | b; co = c; end
         6: begin s = a ^ b; co = c; end
         default: begin s = b; co = c; end
      endcase
      return (co << w) | (s & m);
   endfunction

   function automatic int ref_sh(int w, int code, int a, int c);
      int m = (1 << w) - 1;
      int top = (a >> (w - 1)) & 1;
      int s;
      int co;
      case (code)
         0: begin s = (a << 1) & m;        co = top; end
         1: begin s = a >> 1;              co = a & 1; end
         2: begin s = ((a << 1) & m) | c;  co = top; end
         default: begin s = (a >> 1) | (c << (w - 1)); co = a & 1; end
      endcase
      return (co << w) | s;
   endfunction

   task automatic set_c4(input logic c);
      @(negedge clk);
      se4 = 0; f4 = 3'b000; a4 = 4'hF; b4 = {3'b0, c}; cm4 = 1;
      @(posedge clk); #1;
      cm4 = 0;
   endtask

   task automatic set_c8(input logic c);
      @(negedge clk);
      se8 = 0; f8 = 3'b000; a8 = 8'hFF; b8 = {7'b0, c}; cm8 = 1;
      @(posedge clk); #1;
      cm8 = 0;
   endtask

   // Four-byte chain; sub selects subtract. Expected from 33-bit arithmetic.
   task automatic chain(input logic [31:0] x, input logic [31:0] y,
                        input bit sub);
      logic [31:0] got;
      logic [32:0] exp;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         se8 = 0;
         a8 = x[8*i +: 8];
         b8 = y[8*i +: 8];
         f8 = {1'b0, (i != 0), sub};
         cm8 = 1;
         #1 got[8*i +: 8] = r8;
         @(posedge clk); #1;
         cm8 = 0;
      end
      if (sub) begin
         exp = {1'b0, x} - {1'b0, y};
         check("R10 chain difference", got, exp[31:0]);
         check("R10 chain borrow", {31'b0, c8}, {31'b0, (y > x)});
      end else begin
         exp = {1'b0, x} + {1'b0, y};
         check("R10 chain sum", got, exp[31:0]);
         check("R10 chain carry", {31'b0, c8}, {31'b0, exp[32]});
      end
   endtask

   initial begin
      a8 = 0; b8 = 0; f8 = 0; se8 = 0; sc8 = 0; cm8 = 0;
      a4 = 0; b4 = 0; f4 = 0; se4 = 0; sc4 = 0; cm4 = 0;
      repeat (3) @(posedge clk);
      #1;
      check("R6 reset carry w8", {31'b0, c8}, 32'd0);
      check("R6 reset carry w4", {31'b0, c4}, 32'd0);
      @(negedge clk);
      rst_n = 1;

      // Full function sweep on the narrow copy (R1..R5).
      for (int c = 0; c < 2; c++) begin
         set_c4(c[0]);
         check("R6 carry set", {31'b0, c4}, c);
         for (int f = 0; f < 8; f++) begin
            for (int a = 0; a < 16; a++) begin
               for (int b = 0; b < 16; b++) begin
                  int e;
                  se4 = 0; f4 = f[2:0]; a4 = a[3:0]; b4 = b[3:0];
                  #1;
                  e = ref_fn(4, f, a, b, c);
                  if (f < 2)       check("R1 result/flag", {27'b0, cn4, r4}, e);
                  else if (f < 4)  check("R2 result/flag", {27'b0, cn4, r4}, e);
                  else if (f < 7)  check("R3 result/flag", {27'b0, cn4, r4}, e);
                  else             check("R4 result/flag", {27'b0, cn4, r4}, e);
                  if (f >= 4) check("R5 flag kept", {31'b0, cn4}, c);
               end
            end
         end
      end

      // Full shift sweep (R7, R8); function code set to an unrelated value.
      for (int c = 0; c < 2; c++) begin
         set_c4(c[0]);
         for (int code = 0; code < 4; code++) begin
            for (int a = 0; a < 16; a++) begin
               se4 = 1; sc4 = code[1:0]; a4 = a[3:0]; f4 = 3'b101; b4 = 4'h9;
               #1;
               if (code < 2) check("R7 shift", {27'b0, cn4, r4}, ref_sh(4, code, a, c));
               else          check("R8 rotate", {27'b0, cn4, r4}, ref_sh(4, code, a, c));
            end
         end
      end
      se4 = 0;

      // Zero output (R9).
      for (int a = 0; a < 16; a++) begin
         a4 = a[3:0]; #1;
         check("R9 zero", {31'b0, z4}, (a == 0) ? 1 : 0);
      end
      a8 = 8'h00; #1 check("R9 zero w8", {31'b0, z8}, 32'd1);
      a8 = 8'h80; #1 check("R9 nonzero w8", {31'b0, z8}, 32'd0);

      // Commit gating (R6): an overflowing add without commit leaves carry 0.
      set_c8(1'b0);
      @(negedge clk);
      f8 = 3'b000; a8 = 8'hF0; b8 = 8'h20; cm8 = 0;
      @(posedge clk); #1;
      check("R6 no commit holds", {31'b0, c8}, 32'd0);
      @(negedge clk); cm8 = 1;
      @(posedge clk); #1; cm8 = 0;
      check("R6 commit loads", {31'b0, c8}, 32'd1);

      // Logical and load commits keep the stored carry (R5).
      for (int f = 4; f < 8; f++) begin
         @(negedge clk);
         f8 = f[2:0]; a8 = 8'hFF; b8 = 8'hFF; cm8 = 1;
         @(posedge clk); #1; cm8 = 0;
         check("R5 committed logic keeps carry", {31'b0, c8}, 32'd1);
      end
      set_c8(1'b0);
      @(negedge clk);
      f8 = 3'b111; a8 = 8'h00; b8 = 8'h00; cm8 = 1;
      @(posedge clk); #1; cm8 = 0;
      check("R5 committed load keeps zero carry", {31'b0, c8}, 32'd0);

      // Shift commit moves the outgoing bit into carry (R7).
      @(negedge clk);
      se8 = 1; sc8 = 2'b01; a8 = 8'h01; cm8 = 1;
      @(posedge clk); #1; cm8 = 0; se8 = 0;
      check("R7 shifted bit stored", {31'b0, c8}, 32'd1);

      // Multi-byte chains across 0xFF/0x00 boundaries (R10).
      chain(32'h00FF_FFFF, 32'h0000_0001, 1'b0);
      chain(32'hFFFF_FFFF, 32'h0000_0001, 1'b0);
      chain(32'h12FF_80FF, 32'h00FF_8001, 1'b0);
      chain(32'h0100_0000, 32'h0000_0001, 1'b1);
      chain(32'h0000_0000, 32'h0000_0001, 1'b1);
      chain(32'h8000_0100, 32'h7FFF_01FF, 1'b1);

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule